// File: doc/BRIEF.md
# Contactless Response Timing Trigger

This block is the card-side timing engine for a Type A short-frame exchange. It is clocked by the carrier-derived clock. It watches the demodulated reader signal `mod_n`, which is low while the reader holds a pause in the field. The first pause after idle opens a frame. The block then slices the following carrier cycles into bit slots and decodes Modified Miller symbols into a short 7-bit frame. It classifies the result as a request command or a wake-up command.

A delay counter restarts at the end of every pause while the frame is arriving. The reply strobe is therefore phase-locked to the last pause the reader sent. Once a valid command is recognised, the strobe fires after one of two frame delay times. The value of the last data bit chooses which one. Any other frame content raises a one-cycle abort and returns the block to waiting for a new start of frame.

The downstream transmitter begins sending its reply on `tx_start`. `cmd_valid` and `cmd_wake` tell it which command it is answering.

Top module: `cl_resp_trigger`

## Requirements
- R1: While `rst_n` is low and after its release, `tx_start`, `cmd_valid`, `cmd_wake` and `abort` are all 0.
- R2: While `en` is 0, pauses on `mod_n` start no frame and cause no strobe, valid flag or abort. Dropping `en` while a strobe is pending cancels it and clears `cmd_valid`.
- R3: A falling edge of `mod_n` (pause start) while idle opens a frame. Bit slots are 128 clock cycles long, and the first data slot starts nominally 128 cycles after that edge. Decoding within a slot works as follows:
  - A pause at the nominal slot start is bit 0.
  - A pause 64 cycles into the slot is bit 1.
  - A slot without a pause is bit 0 after a 1 bit. After a 0 bit, it ends the frame.
  - The 0 that precedes the end is an end marker, not data.
  - Data bits arrive least significant bit first.
- R4: A frame of exactly 7 data bits equal to 0x26 sets `cmd_valid`=1 with `cmd_wake`=0. A frame equal to 0x52 sets `cmd_valid`=1 with `cmd_wake`=1. `cmd_wake` is stable while `cmd_valid` is high.
- R5: After a valid command, `tx_start` is high for exactly one cycle. Let N be the first clock edge that samples `mod_n` high at the end of the frame's last pause. `tx_start` is high in the cycle after edge N+1172 if the last data bit (bit 6) is 0, and after edge N+1236 if it is 1.
- R6: Once the frame has ended, further pauses do not restart the delay and do not move the strobe.
- R7: A 7-bit frame whose value is neither command gives a one-cycle `abort` pulse, with no strobe and no `cmd_valid`. The next frame is accepted normally.
- R8: A frame with more or fewer than 7 data bits gives an `abort` pulse and no strobe.
- R9: `cmd_valid` is high in the strobe cycle and low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier-derived clock, one cycle per carrier period |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable; 0 holds the block idle |
| mod_n | input | 1 | Demodulated reader field, 0 during a pause |
| tx_start | output | 1 | One-cycle reply start strobe |
| cmd_valid | output | 1 | A recognised command is awaiting its reply |
| cmd_wake | output | 1 | 1 for the wake-up command, 0 for the request command |
| abort | output | 1 | One-cycle pulse on an unusable frame |

## Verification
A slot phase that has slipped misclassifies pauses, so `cmd_wake` flips or an abort appears at the end of the frame, about two slots after the last pause. A delay counter that misses a restart, or restarts after the end, moves `tx_start` off its exact cycle by tens to hundreds of cycles. Comparing against the cycle computed from the last pause end exposes this. A frame-state error leaves `cmd_valid` set past the strobe, or lets a strobe follow an abort. Both show within one cycle of the event.

// File: rtl/crt_pkg.sv
package crt_pkg;

  // Slot classification: bit 1 = pause seen in late half, bit 0 = early half
  typedef enum logic [1:0] {
    SYM_NONE  = 2'd0,
    SYM_EARLY = 2'd1,
    SYM_LATE  = 2'd2,
    SYM_BOTH  = 2'd3
  } crt_sym_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RX   = 2'd1,
    ST_WAIT = 2'd2
  } crt_state_e;

endpackage

// File: rtl/crt_edge_sync.sv
module crt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall,
  output logic rise
);

  logic [STAGES:0] sr_q;
  logic [STAGES:0] sr_d;

  always_comb begin
    sr_d = {sr_q[STAGES-1:0], din};
  end

  // idle field level is high (carrier present)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '1;
    end else begin
      sr_q <= sr_d;
    end
  end

  assign fall = sr_q[STAGES] & ~sr_q[STAGES-1];
  assign rise = ~sr_q[STAGES] & sr_q[STAGES-1];

endmodule

// File: rtl/crt_slot_slicer.sv
module crt_slot_slicer
  import crt_pkg::*;
#(
  parameter int BIT_CYC = 128
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run,
  input  logic     start,
  input  logic     fall,
  output logic     sym_valid,
  output crt_sym_e sym
);

  localparam int PH_W = $clog2(BIT_CYC);
  localparam logic [PH_W-1:0] PH_QTR  = PH_W'(BIT_CYC / 4);
  localparam logic [PH_W-1:0] PH_HALF = PH_W'(BIT_CYC / 2);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(BIT_CYC - 1);

  logic [PH_W-1:0] phase_q, phase_d;
  logic early_q, early_d;
  logic late_q, late_d;
  logic skip_q, skip_d;
  logic hit_early, hit_late, seen_early, seen_late, slot_end;

  always_comb begin
    hit_early  = run && fall && (phase_q < PH_HALF);
    hit_late   = run && fall && !(phase_q < PH_HALF);
    seen_early = early_q | hit_early;
    seen_late  = late_q | hit_late;
    slot_end   = run && (phase_q == PH_LAST);
    sym_valid  = slot_end && !skip_q;
    sym        = crt_sym_e'({seen_late, seen_early});
  end

  always_comb begin
    phase_d = phase_q;
    early_d = early_q;
    late_d  = late_q;
    skip_d  = skip_q;
    if (start) begin
      // slot windows sit a quarter slot ahead of the nominal bit start
      phase_d = PH_QTR;
      early_d = 1'b0;
      late_d  = 1'b0;
      skip_d  = 1'b1;
    end else if (run) begin
      if (slot_end) begin
        phase_d = '0;
        early_d = 1'b0;
        late_d  = 1'b0;
        skip_d  = 1'b0;
      end else begin
        phase_d = phase_q + 1'b1;
        early_d = seen_early;
        late_d  = seen_late;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      early_q <= 1'b0;
      late_q  <= 1'b0;
      skip_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      early_q <= early_d;
      late_q  <= late_d;
      skip_q  <= skip_d;
    end
  end

endmodule

// File: rtl/crt_frame_rx.sv
module crt_frame_rx
  import crt_pkg::*;
#(
  parameter int FRAME_BITS = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  sym_valid,
  input  crt_sym_e              sym,
  output logic                  done,
  output logic                  err,
  output logic [FRAME_BITS-1:0] data,
  output logic                  last_bit
);

  localparam int TOT   = FRAME_BITS + 1;
  localparam int CNT_W = $clog2(TOT + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(TOT);

  logic [TOT-1:0]   bits_q, bits_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             prev_q, prev_d;
  logic             have_bit, bit_v, frame_end;

  always_comb begin
    bits_d    = bits_q;
    cnt_d     = cnt_q;
    prev_d    = prev_q;
    done      = 1'b0;
    err       = 1'b0;
    have_bit  = 1'b0;
    bit_v     = 1'b0;
    frame_end = 1'b0;
    if (sym_valid) begin
      case (sym)
        SYM_BOTH:  err = 1'b1;
        SYM_LATE:  begin have_bit = 1'b1; bit_v = 1'b1; end
        SYM_EARLY: begin have_bit = 1'b1; bit_v = 1'b0; end
        default: begin
          if (prev_q) begin
            have_bit = 1'b1;
          end else begin
            frame_end = 1'b1;
          end
        end
      endcase
    end
    if (have_bit) begin
      if (cnt_q == CNT_FULL) begin
        err = 1'b1;
      end else begin
        for (int i = 0; i < TOT; i++) begin
          if (CNT_W'(i) == cnt_q) bits_d[i] = bit_v;
        end
        cnt_d  = cnt_q + 1'b1;
        prev_d = bit_v;
      end
    end
    if (frame_end) begin
      // the closing zero is counted, so a good frame holds FRAME_BITS+1
      if (cnt_q == CNT_FULL) done = 1'b1;
      else                   err  = 1'b1;
    end
    if (clr) begin
      bits_d = '0;
      cnt_d  = '0;
      prev_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
      cnt_q  <= '0;
      prev_q <= 1'b0;
    end else begin
      bits_q <= bits_d;
      cnt_q  <= cnt_d;
      prev_q <= prev_d;
    end
  end

  assign data     = bits_q[FRAME_BITS-1:0];
  assign last_bit = bits_q[FRAME_BITS-1];

endmodule

// File: rtl/crt_fdt_timer.sv
module crt_fdt_timer #(
  parameter int LAT      = 2,
  parameter int DLY_ZERO = 1172,
  parameter int DLY_ONE  = 1236
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic arm,
  input  logic sel_one,
  output logic fire
);

  localparam int DMAX  = (DLY_ONE > DLY_ZERO) ? DLY_ONE : DLY_ZERO;
  localparam int CNT_W = $clog2(DMAX + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;
  localparam logic [CNT_W-1:0] LAT_V   = CNT_W'(LAT);
  localparam logic [CNT_W-1:0] HIT0    = CNT_W'(DLY_ZERO - 1);
  localparam logic [CNT_W-1:0] HIT1    = CNT_W'(DLY_ONE - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             fire_q, fire_d;

  always_comb begin
    cnt_d = cnt_q;
    if (restart) begin
      // preload with the synchroniser latency so counts refer to the pin
      cnt_d = LAT_V;
    end else if (run && (cnt_q != CNT_TOP)) begin
      cnt_d = cnt_q + 1'b1;
    end
    fire_d = arm && !restart && (cnt_q == (sel_one ? HIT1 : HIT0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      fire_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      fire_q <= fire_d;
    end
  end

  assign fire = fire_q;

endmodule

// File: rtl/cl_resp_trigger.sv
module cl_resp_trigger
  import crt_pkg::*;
#(
  parameter int                    BIT_CYC     = 128,
  parameter int                    FRAME_BITS  = 7,
  parameter int                    SYNC_STAGES = 2,
  parameter int                    DLY_ZERO    = 1172,
  parameter int                    DLY_ONE     = 1236,
  parameter logic [FRAME_BITS-1:0] REQ_CODE    = 'h26,
  parameter logic [FRAME_BITS-1:0] WAKE_CODE   = 'h52
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic mod_n,
  output logic tx_start,
  output logic cmd_valid,
  output logic cmd_wake,
  output logic abort
);

  logic [1:0] rst_sr;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sr <= '0;
    end else begin
      rst_sr <= {rst_sr[0], 1'b1};
    end
  end
  assign rst_n_i = rst_sr[1];

  logic                  pause_fall, pause_rise;
  logic                  sym_valid;
  crt_sym_e              sym;
  logic                  frm_done, frm_err, frm_last;
  logic [FRAME_BITS-1:0] frm_data;
  logic                  fire;
  crt_state_e            st_q, st_d;
  logic                  valid_q, valid_d, wake_q, wake_d, abort_q, abort_d;
  logic                  sof, in_rx, in_wait;

  assign in_rx   = (st_q == ST_RX);
  assign in_wait = (st_q == ST_WAIT);

  crt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_i),
    .din   (mod_n),
    .fall  (pause_fall),
    .rise  (pause_rise)
  );

  crt_slot_slicer #(.BIT_CYC(BIT_CYC)) u_slicer (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .run       (in_rx),
    .start     (sof),
    .fall      (pause_fall),
    .sym_valid (sym_valid),
    .sym       (sym)
  );

  crt_frame_rx #(.FRAME_BITS(FRAME_BITS)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .clr       (sof),
    .sym_valid (sym_valid),
    .sym       (sym),
    .done      (frm_done),
    .err       (frm_err),
    .data      (frm_data),
    .last_bit  (frm_last)
  );

  crt_fdt_timer #(
    .LAT      (SYNC_STAGES),
    .DLY_ZERO (DLY_ZERO),
    .DLY_ONE  (DLY_ONE)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .run     (st_q != ST_IDLE),
    .restart (pause_rise && in_rx),
    .arm     (in_wait && en),
    .sel_one (frm_last),
    .fire    (fire)
  );

  always_comb begin
    st_d    = st_q;
    valid_d = valid_q;
    wake_d  = wake_q;
    abort_d = 1'b0;
    sof     = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (en && pause_fall) begin
          sof  = 1'b1;
          st_d = ST_RX;
        end
      end
      ST_RX: begin
        if (!en) begin
          st_d = ST_IDLE;
        end else if (frm_err) begin
          abort_d = 1'b1;
          st_d    = ST_IDLE;
        end else if (frm_done) begin
          if ((frm_data == REQ_CODE) || (frm_data == WAKE_CODE)) begin
            st_d    = ST_WAIT;
            valid_d = 1'b1;
            wake_d  = (frm_data == WAKE_CODE);
          end else begin
            abort_d = 1'b1;
            st_d    = ST_IDLE;
          end
        end
      end
      ST_WAIT: begin
        if (!en || fire) begin
          st_d    = ST_IDLE;
          valid_d = 1'b0;
          wake_d  = 1'b0;
        end
      end
      default: begin
        st_d    = ST_IDLE;
        valid_d = 1'b0;
        wake_d  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      st_q    <= ST_IDLE;
      valid_q <= 1'b0;
      wake_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      valid_q <= valid_d;
      wake_q  <= wake_d;
      abort_q <= abort_d;
    end
  end

  assign tx_start  = fire;
  assign cmd_valid = valid_q;
  assign cmd_wake  = wake_q;
  assign abort     = abort_q;

endmodule

// File: rtl/crt_checker.sv
module crt_checker (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic tx_start,
  input logic cmd_valid,
  input logic cmd_wake,
  input logic abort
);

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start); // R5

  AST_STROBE_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> cmd_valid); // R9

  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !cmd_valid); // R9

  AST_WAKE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wake |-> cmd_valid); // R4

  AST_WAKE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> (!cmd_valid || $stable(cmd_wake))); // R4

  AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !abort); // R7

  AST_ABORT_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> (!cmd_valid && !tx_start)); // R7

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!tx_start && !cmd_valid && !abort)); // R2

endmodule

bind cl_resp_trigger crt_checker u_crt_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .tx_start  (tx_start),
  .cmd_valid (cmd_valid),
  .cmd_wake  (cmd_wake),
  .abort     (abort)
);

// File: tb/tb_cl_resp_trigger.sv
`timescale 1ns/1ps
module tb_cl_resp_trigger;

  localparam int BIT  = 128;
  localparam int D0   = 1172;
  localparam int D1   = 1236;
  localparam int NVEC = 6;
  // {code[9:3], exp_valid[2], exp_wake[1], exp_abort[0]}
  localparam logic [9:0] VEC [NVEC] = '{
    {7'h26, 3'b100},
    {7'h52, 3'b110},
    {7'h27, 3'b001},
    {7'h52, 3'b110},
    {7'h53, 3'b001},
    {7'h26, 3'b100}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic mod_n = 1'b1;
  logic tx_start, cmd_valid, cmd_wake, abort;

  int cyc = 0;
  int n_checks = 0;
  int n_fail = 0;
  int last_rise = 0;
  int n_strobe, strobe_cyc, n_abort;
  logic valid_at_strobe, valid_after, prev_strobe, seen_valid, wake_seen;
  logic finished = 1'b0;

  always #2 clk = ~clk;

  cl_resp_trigger dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .mod_n     (mod_n),
    .tx_start  (tx_start),
    .cmd_valid (cmd_valid),
    .cmd_wake  (cmd_wake),
    .abort     (abort)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (tx_start) begin
      n_strobe = n_strobe + 1;
      if (n_strobe == 1) begin
        strobe_cyc      = cyc;
        valid_at_strobe = cmd_valid;
      end
    end
    if (prev_strobe) valid_after = cmd_valid;
    prev_strobe = tx_start;
    if (abort) n_abort = n_abort + 1;
    if (cmd_valid && !seen_valid) begin
      seen_valid = 1'b1;
      wake_seen  = cmd_wake;
    end
  end

  task automatic clear_mon();
    n_strobe = 0; strobe_cyc = -1; n_abort = 0;
    valid_at_strobe = 1'b0; valid_after = 1'b1; prev_strobe = 1'b0;
    seen_valid = 1'b0; wake_seen = 1'b0;
  endtask

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic pause_at(input int t);
    wait_to(t);
    mod_n = 1'b0;
    wait_to(t + 32);
    mod_n = 1'b1;
    last_rise = t + 32;
  endtask

  // Modified Miller frame: start pause, data LSB first, closing zero, idle slot
  task automatic send_frame(input logic [15:0] bits, input int n);
    int t0;
    int t;
    logic prev;
    wait_to(cyc + 8);
    t0 = cyc;
    pause_at(t0);
    prev = 1'b0;
    for (int i = 0; i < n; i++) begin
      t = t0 + BIT * (i + 1);
      if (bits[i]) begin
        pause_at(t + BIT / 2);
        prev = 1'b1;
      end else if (!prev) begin
        pause_at(t);
      end else begin
        prev = 1'b0;
      end
    end
    t = t0 + BIT * (n + 1);
    if (!prev) pause_at(t);
    wait_to(t0 + BIT * (n + 3));
  endtask

  initial begin
    int exp_cyc;
    clear_mon();
    repeat (5) @(negedge clk);
    // R1: reset state
    check({tx_start, cmd_valid, cmd_wake, abort} == 4'b0, "R1 in reset",
          int'({tx_start, cmd_valid, cmd_wake, abort}), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check({tx_start, cmd_valid, cmd_wake, abort} == 4'b0, "R1 after release",
          int'({tx_start, cmd_valid, cmd_wake, abort}), 0);

    // R2: disabled block ignores a complete request frame
    clear_mon();
    send_frame(16'h0026, 7);
    wait_to(last_rise + D1 + 40);
    check(n_strobe == 0 && n_abort == 0 && !seen_valid, "R2 disabled",
          n_strobe + n_abort, 0);
    en = 1'b1;
    repeat (4) @(negedge clk);

    // vector table: R3 decoding, R4 classification, R5 delay, R7 abort, R9 valid
    for (int v = 0; v < NVEC; v++) begin
      logic [6:0] code;
      code = VEC[v][9:3];
      clear_mon();
      send_frame({9'd0, code}, 7);
      wait_to(last_rise + D1 + 40);
      check(seen_valid == VEC[v][2], "R4 valid flag", int'(seen_valid), int'(VEC[v][2]));
      check(n_abort == int'(VEC[v][0]), "R7 abort count", n_abort, int'(VEC[v][0]));
      if (VEC[v][2]) begin
        check(wake_seen == VEC[v][1], "R3 decoded command type", int'(wake_seen), int'(VEC[v][1]));
        exp_cyc = last_rise + 1 + (code[6] ? D1 : D0);
        check(n_strobe == 1 && strobe_cyc == exp_cyc, "R5 strobe cycle", strobe_cyc, exp_cyc);
        check(valid_at_strobe && !valid_after, "R9 valid around strobe",
              int'({valid_at_strobe, valid_after}), 2);
      end else begin
        check(n_strobe == 0, "R7 no strobe on bad code", n_strobe, 0);
      end
    end

    // R8: too few data bits
    clear_mon();
    send_frame(16'h0005, 3);
    wait_to(last_rise + D1 + 40);
    check(n_abort == 1 && n_strobe == 0, "R8 short frame", n_abort * 10 + n_strobe, 10);

    // R8: too many data bits
    clear_mon();
    send_frame(16'h00A6, 8);
    wait_to(last_rise + D1 + 40);
    check(n_abort == 1 && n_strobe == 0, "R8 long frame", n_abort * 10 + n_strobe, 10);

    // R7: a good frame right after an abort is accepted
    clear_mon();
    send_frame(16'h0026, 7);
    wait_to(last_rise + D1 + 40);
    check(seen_valid && n_strobe == 1 && strobe_cyc == last_rise + 1 + D0,
          "R7 recovery after abort", strobe_cyc, last_rise + 1 + D0);

    // R6: a pause after the frame end does not move the strobe
    clear_mon();
    send_frame(16'h0052, 7);
    exp_cyc = last_rise + 1 + D1;
    wait_to(cyc + 4);
    mod_n = 1'b0;
    wait_to(cyc + 32);
    mod_n = 1'b1;
    wait_to(exp_cyc + 60);
    check(n_strobe == 1 && strobe_cyc == exp_cyc, "R6 late pause ignored", strobe_cyc, exp_cyc);

    // R2: dropping enable while waiting cancels the strobe
    clear_mon();
    send_frame(16'h0026, 7);
    wait_to(last_rise + 600);
    check(cmd_valid == 1'b1, "R4 valid while waiting", int'(cmd_valid), 1);
    en = 1'b0;
    wait_to(last_rise + D1 + 40);
    check(n_strobe == 0 && !cmd_valid, "R2 cancel on disable", n_strobe, 0);
    en = 1'b1;
    repeat (4) @(negedge clk);

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    wait_to(150000);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule